// File: doc/BRIEF.md
# Hash Engine Memory-Fetch Sequencer

This block drives a SHA-256 compression engine from a local data memory. Software programs a block count and a 64-byte aligned memory base through byte-wide registers on a simple register bus, then writes a start command. The sequencer reads each 64-byte block as sixteen 32-bit words and streams them to the engine with the byte order corrected. It then hands the engine the 256-bit chaining state and waits for the engine's result. After the last block it raises a done flag and, if enabled, an interrupt.

The chaining state lives in the sequencer between runs, so one message can be hashed over several runs. A start command either loads the standard SHA-256 initial values first or continues from the stored state. A separate command stores the eight state words back to memory. Padding and the compression rounds are handled outside this block.

While a run or a write-back is in progress, the sequencer owns the memory port. Commands written during that time are dropped.

Top module: `hash_fetch_seq`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low, and neither `mem_req` nor `eng_req` nor `eng_wvalid` is asserted. Register offsets: 0 control, 1 status, 2 block count, 3 base low, 4 base high. Reads are combinational from `reg_addr`.
- R2: Writing the control register with bit 0 (execute) set while idle starts a run of N+1 consecutive 64-byte blocks. N is the 4-bit value in the count register, so a count of 15 gives the maximum run of 16 blocks (1 KB).
- R3: For block b and word w (w = 0..15, in increasing order), the sequencer reads byte address base + 64*b + 4*w. One cycle after the read it presents the word on `eng_word` with `eng_wvalid` high. The memory byte in bits 7:0 (the lowest address) goes to bits 31:24, bits 15:8 to 23:16, bits 23:16 to 15:8, and bits 31:24 to 7:0.
- R4: After the sixteenth word of a block, `eng_req` rises with the chaining state on `eng_hin`, and both stay steady until `eng_done`. At `eng_done`, `eng_hout` becomes the new chaining state. No word is streamed while `eng_req` is high.
- R5: If control bit 1 (init) is written together with execute, the state is set to the SHA-256 initial values before the first block: 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19, with H0 in `eng_hin[255:224]`. With execute alone, the run continues from the stored state.
- R6: Writing control bit 2 (write-back) with bit 0 clear, while idle, writes state words H0..H7 to byte addresses base + 4*k (k = 0..7), in that order. H0 is the word carried in `eng_hin[255:224]`, and each word is written without byte swapping.
- R7: The base-low register keeps only written bits 7:6, which supply address bits 7:6; its other bits read 0. The base-high register supplies address bits 15:8.
- R8: Status bit 0 shows busy, which is high from acceptance of a command until it completes. Bit 2 is the done flag: it is set when a run or write-back completes, and writing 1 to it clears it. Bit 3 is a read/write interrupt enable. `irq` is high exactly when both enable and done are set.
- R9: Control bits 0, 1 and 2 always read 0. Control bits 6:4 (algorithm select, 000 = SHA-256) read back as written and have no other effect.
- R10: A command written while busy is ignored. The count and the base are sampled when a command is accepted, so writes to them during a run do not change that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| eng_wvalid | output | 1 | Message word valid to engine |
| eng_word | output | 32 | Message word, first message byte in bits 31:24 |
| eng_req | output | 1 | Compression request, held until done |
| eng_hin | output | 256 | Chaining state to engine, H0 in the top word |
| eng_done | input | 1 | Engine completion pulse |
| eng_hout | input | 256 | Updated chaining state from engine |

## Verification
The memory holds a distinct value in every word, and the stub engine folds the words it receives, in order, into its result. Any wrong address, word order or byte order therefore shows up both in the streamed words and in the written-back state. The tests cover:
- A single-block run started with init, followed by a write-back. This separates the initial-value path from the stored-state path.
- A three-block run that continues from the stored state.
- A repeat of the init run, which must reproduce the first result.
- A 16-block run, to check the count limit.
- A run during which the count, the base and the commands are rewritten. Only the sampled values may take effect.

Register readback of the masked base and of the algorithm-select bits, and the done/enable/interrupt combinations, are checked at the bus.

// File: rtl/hash_fetch_seq_pkg.sv
package hash_fetch_seq_pkg;

    localparam int WORD_W  = 32;
    localparam int H_WORDS = 8;
    localparam int HASH_W  = WORD_W * H_WORDS;
    localparam int ADDR_W  = 16;

    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CNT  = 3'd2;
    localparam logic [2:0] OFF_BLO  = 3'd3;
    localparam logic [2:0] OFF_BHI  = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DRAIN,
        S_HASH,
        S_WBACK
    } seq_state_e;

    function automatic logic [HASH_W-1:0] sha256_iv();
        return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    endfunction

endpackage

// File: rtl/hash_fetch_seq_bswap.sv
module hash_fetch_seq_bswap #(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] din,
    output logic [BYTES*8-1:0] dout
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign dout[(BYTES-1-i)*8 +: 8] = din[i*8 +: 8];
    end
endmodule

// File: rtl/hash_fetch_seq_regs.sv
module hash_fetch_seq_regs
    import hash_fetch_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy_i,
    input  logic              done_set_i,
    output logic              go_run_o,
    output logic              go_init_o,
    output logic              go_wb_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              done_o,
    output logic              ie_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       blo;
        logic [7:0]       bhi;
        logic [2:0]       alg;
        logic             done;
        logic             ie;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl, wr_stat;

    always_comb begin
        d       = q;
        wr_ctrl = reg_we && (reg_addr == OFF_CTRL);
        wr_stat = reg_we && (reg_addr == OFF_STAT);

        if (wr_ctrl) d.alg = reg_wdata[6:4];
        if (reg_we && reg_addr == OFF_CNT) d.cnt = reg_wdata[CNT_W-1:0];
        if (reg_we && reg_addr == OFF_BLO) d.blo = reg_wdata[7:6];
        if (reg_we && reg_addr == OFF_BHI) d.bhi = reg_wdata;
        if (wr_stat) begin
            d.ie = reg_wdata[3];
            if (reg_wdata[2]) d.done = 1'b0;
        end
        if (done_set_i) d.done = 1'b1;

        go_run_o  = wr_ctrl && !busy_i && reg_wdata[0];
        go_init_o = go_run_o && reg_wdata[1];
        go_wb_o   = wr_ctrl && !busy_i && !reg_wdata[0] && reg_wdata[2];

        unique case (reg_addr)
            OFF_CTRL: reg_rdata = {1'b0, q.alg, 4'b0000};
            OFF_STAT: reg_rdata = {4'b0000, q.ie, q.done, 1'b0, busy_i};
            OFF_CNT:  reg_rdata = 8'(q.cnt);
            OFF_BLO:  reg_rdata = {q.blo, 6'b000000};
            OFF_BHI:  reg_rdata = q.bhi;
            default:  reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o  = q.cnt;
    assign base_o = {q.bhi, q.blo, 6'b000000};
    assign done_o = q.done;
    assign ie_o   = q.ie;
    assign irq_o  = q.ie && q.done;
endmodule

// File: rtl/hash_fetch_seq_fsm.sv
module hash_fetch_seq_fsm
    import hash_fetch_seq_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BLK_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_run_i,
    input  logic              go_init_i,
    input  logic              go_wb_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              busy_o,
    output logic              done_set_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              rd_valid_o,
    output logic              eng_req,
    output logic [HASH_W-1:0] eng_hin,
    input  logic              eng_done,
    input  logic [HASH_W-1:0] eng_hout
);
    localparam int WIDX_W = $clog2(BLK_WORDS);
    localparam int OFF_W  = CNT_W + WIDX_W + 2;

    typedef struct packed {
        seq_state_e        state;
        logic [WIDX_W-1:0] widx;
        logic [CNT_W-1:0]  blk;
        logic [CNT_W-1:0]  last;
        logic [ADDR_W-1:0] base;
        logic [HASH_W-1:0] h;
        logic              rdv;
    } seq_t;

    seq_t q, d;
    logic [OFF_W-1:0] run_off;

    always_comb begin
        d          = q;
        d.rdv      = 1'b0;
        done_set_o = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = q.base;
        mem_wdata  = '0;
        eng_req    = 1'b0;
        run_off    = {q.blk, q.widx, 2'b00};

        unique case (q.state)
            S_IDLE: begin
                d.widx = '0;
                d.blk  = '0;
                if (go_run_i) begin
                    d.state = S_FETCH;
                    d.last  = cnt_i;
                    d.base  = base_i;
                    if (go_init_i) d.h = sha256_iv();
                end else if (go_wb_i) begin
                    d.state = S_WBACK;
                    d.base  = base_i;
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.base + ADDR_W'(run_off);
                d.rdv    = 1'b1;
                d.widx   = q.widx + 1'b1;
                if (q.widx == WIDX_W'(BLK_WORDS - 1)) d.state = S_DRAIN;
            end
            S_DRAIN: begin
                d.state = S_HASH;
            end
            S_HASH: begin
                eng_req = 1'b1;
                if (eng_done) begin
                    d.h    = eng_hout;
                    d.widx = '0;
                    if (q.blk == q.last) begin
                        d.state    = S_IDLE;
                        done_set_o = 1'b1;
                    end else begin
                        d.blk   = q.blk + 1'b1;
                        d.state = S_FETCH;
                    end
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base + ADDR_W'({q.widx, 2'b00});
                mem_wdata = q.h[HASH_W-1 - int'(q.widx)*WORD_W -: WORD_W];
                d.widx    = q.widx + 1'b1;
                if (q.widx == WIDX_W'(H_WORDS - 1)) begin
                    d.state    = S_IDLE;
                    done_set_o = 1'b1;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o     = (q.state != S_IDLE);
    assign rd_valid_o = q.rdv;
    assign eng_hin    = q.h;
endmodule

// File: rtl/hash_fetch_seq.sv
module hash_fetch_seq
    import hash_fetch_seq_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BLK_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [15:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          eng_wvalid,
    output logic [31:0]   eng_word,
    output logic          eng_req,
    output logic [255:0]  eng_hin,
    input  logic          eng_done,
    input  logic [255:0]  eng_hout
);
    logic              busy_w, done_w, ie_w, done_set_w;
    logic              go_run_w, go_init_w, go_wb_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [ADDR_W-1:0] base_w;

    hash_fetch_seq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy_w),
        .done_set_i (done_set_w),
        .go_run_o   (go_run_w),
        .go_init_o  (go_init_w),
        .go_wb_o    (go_wb_w),
        .cnt_o      (cnt_w),
        .base_o     (base_w),
        .done_o     (done_w),
        .ie_o       (ie_w),
        .irq_o      (irq)
    );

    hash_fetch_seq_fsm #(.CNT_W(CNT_W), .BLK_WORDS(BLK_WORDS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_run_i   (go_run_w),
        .go_init_i  (go_init_w),
        .go_wb_i    (go_wb_w),
        .cnt_i      (cnt_w),
        .base_i     (base_w),
        .busy_o     (busy_w),
        .done_set_o (done_set_w),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rd_valid_o (eng_wvalid),
        .eng_req    (eng_req),
        .eng_hin    (eng_hin),
        .eng_done   (eng_done),
        .eng_hout   (eng_hout)
    );

    hash_fetch_seq_bswap #(.BYTES(WORD_W / 8)) u_swap (
        .din  (mem_rdata),
        .dout (eng_word)
    );
endmodule

// File: rtl/hash_fetch_seq_chk.sv
module hash_fetch_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         mem_req,
    input logic [15:0]  mem_addr,
    input logic         eng_req,
    input logic         eng_done,
    input logic         eng_wvalid,
    input logic [255:0] eng_hin
);
    // R4: request held until the engine answers
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> eng_req);

    // R4: chaining state steady while waiting
    a_r4_hin_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> $stable(eng_hin));

    // R4: no word streamed during a request
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !eng_wvalid);

    // R10: memory port used only while a command is active
    a_r10_mem_owned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R3: words reach the engine only inside a run
    a_r3_word_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wvalid |-> busy);

    // R3: accesses are word aligned
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R8: done rises exactly as busy ends
    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));
endmodule

bind hash_fetch_seq hash_fetch_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy_w),
    .done       (done_w),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .eng_req    (eng_req),
    .eng_done   (eng_done),
    .eng_wvalid (eng_wvalid),
    .eng_hin    (eng_hin)
);

// File: tb/tb_hash_fetch_seq.sv
`timescale 1ns/1ps
module tb_hash_fetch_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic         irq;
    logic         mem_req, mem_we;
    logic [15:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic         eng_wvalid;
    logic [31:0]  eng_word;
    logic         eng_req;
    logic [255:0] eng_hin;
    logic         eng_done = 1'b0;
    logic [255:0] eng_hout = '0;

    int checks = 0;
    int fails  = 0;

    hash_fetch_seq dut (.*);

    always #5 clk = ~clk;

    // ---------------- memory model and engine stub ----------------
    logic [31:0] bmem [0:1023];
    logic [31:0] stub_acc = '0;
    logic [1:0]  stub_lat = '0;

    function automatic logic [31:0] swap32(logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [255:0] stub_fn(logic [255:0] h, logic [31:0] acc);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w;
            w = h[255 - i*32 -: 32];
            r[255 - i*32 -: 32] = {w[30:0], w[31]} ^ acc ^ 32'(i);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= bmem[mem_addr[11:2]];
        if (mem_req && mem_we)  bmem[mem_addr[11:2]] <= mem_wdata;
        eng_done <= 1'b0;
        if (eng_wvalid) stub_acc <= stub_acc * 33 ^ eng_word;
        if (eng_req && !eng_done) begin
            if (stub_lat == 2'd2) begin
                eng_done <= 1'b1;
                eng_hout <= stub_fn(eng_hin, stub_acc);
                stub_acc <= '0;
                stub_lat <= '0;
            end else begin
                stub_lat <= stub_lat + 1'b1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [31:0]  exp_words[$];
    logic [47:0]  exp_wb[$];
    logic [255:0] model_h = '0;
    logic         ie_sw = 1'b0;

    // monitor: compares design outputs against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && eng_wvalid) begin
            if (exp_words.size() == 0) chk(0, "R3 unexpected word", 64'(eng_word), 0);
            else begin
                logic [31:0] e;
                e = exp_words.pop_front();
                chk(eng_word == e, "R3 word order/byte order", 64'(eng_word), 64'(e));
            end
        end
        if (rst_n && mem_req && mem_we) begin
            if (exp_wb.size() == 0) chk(0, "R6 unexpected write", 64'({mem_addr, mem_wdata}), 0);
            else begin
                logic [47:0] e;
                e = exp_wb.pop_front();
                chk({mem_addr, mem_wdata} == e, "R6 write-back addr/data",
                    64'({mem_addr, mem_wdata}), 64'(e));
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_base(input logic [15:0] b);
        wr(3'd3, b[7:0]);
        wr(3'd4, b[15:8]);
    endtask

    task automatic wait_done(input string tag);
        logic [7:0] s;
        int n = 0;
        s = 8'h00;
        while (!s[2] && n < 5000) begin
            rd(3'd1, s);
            n++;
        end
        chk(s[2] == 1'b1, {tag, " R8 done set"}, 64'(s), 64'h04);
        chk(s[0] == 1'b0, {tag, " R8 busy cleared"}, 64'(s[0]), 0);
        chk(irq == ie_sw, {tag, " R8 irq follows enable"}, 64'(irq), 64'(ie_sw));
        wr(3'd1, {4'b0000, ie_sw, 3'b100});
        rd(3'd1, s);
        chk(s[2] == 1'b0, {tag, " R8 done W1C"}, 64'(s), 0);
    endtask

    task automatic push_run(input int cnt, input logic [15:0] base, input bit init);
        if (init) model_h = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                             32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
        for (int b = 0; b <= cnt; b++) begin
            logic [31:0] acc;
            acc = '0;
            for (int w = 0; w < 16; w++) begin
                logic [15:0] a;
                logic [31:0] x;
                a = base + 16'(b*64 + w*4);
                x = swap32(bmem[a[11:2]]);
                exp_words.push_back(x);
                acc = acc * 33 ^ x;
            end
            model_h = stub_fn(model_h, acc);
        end
    endtask

    task automatic run(input int cnt, input logic [15:0] base, input bit init, input string tag);
        wr(3'd2, 8'(cnt));
        set_base(base);
        push_run(cnt, base, init);
        wr(3'd0, init ? 8'h03 : 8'h01);
        wait_done(tag);
        chk(exp_words.size() == 0, {tag, " R2 all blocks streamed"}, 64'(exp_words.size()), 0);
    endtask

    task automatic wback(input logic [15:0] base, input string tag);
        set_base(base);
        for (int k = 0; k < 8; k++)
            exp_wb.push_back({base + 16'(4*k), model_h[255 - k*32 -: 32]});
        wr(3'd0, 8'h04);
        wait_done(tag);
        chk(exp_wb.size() == 0, {tag, " R6 eight words written"}, 64'(exp_wb.size()), 0);
    endtask

    logic [255:0] first_h;

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 1024; i++) bmem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h0badf00d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 8'h00, "R1 register reset value", 64'(v), 0);
        end
        chk(irq == 1'b0 && mem_req == 1'b0 && eng_req == 1'b0 && eng_wvalid == 1'b0,
            "R1 outputs idle", 64'({irq, mem_req, eng_req, eng_wvalid}), 0);

        // R9 control readback
        wr(3'd0, 8'h70);
        rd(3'd0, v);
        chk(v == 8'h70, "R9 algorithm bits read back", 64'(v), 64'h70);
        chk(mem_req == 1'b0, "R9 no command from select bits", 64'(mem_req), 0);
        wr(3'd0, 8'h00);

        // R7 base masking
        wr(3'd3, 8'hFF);
        rd(3'd3, v);
        chk(v == 8'hC0, "R7 base low keeps bits 7:6", 64'(v), 64'hC0);
        wr(3'd4, 8'h12);
        rd(3'd4, v);
        chk(v == 8'h12, "R7 base high", 64'(v), 64'h12);

        // R5 init run, single block, then write-back
        run(0, 16'h0040, 1'b1, "R5 init run");
        rd(3'd0, v);
        chk(v == 8'h00, "R9 command bits self clear", 64'(v), 0);
        first_h = model_h;
        wback(16'h0300, "R6 wb after init");

        // R2/R5 continue over three blocks
        run(2, 16'h01C0, 1'b0, "R5 continue run");
        wback(16'h0340, "R6 wb after continue");

        // R5 init again reproduces first result
        run(0, 16'h0040, 1'b1, "R5 reinit run");
        chk(model_h == first_h, "R5 model repeat", 64'(model_h[31:0]), 64'(first_h[31:0]));
        wback(16'h0380, "R6 wb after reinit");

        // R2 maximum run of 16 blocks, interrupt enabled
        ie_sw = 1'b1;
        wr(3'd1, 8'h08);
        run(15, 16'h0800, 1'b1, "R2 max run");
        wback(16'h03C0, "R6 wb after max");

        // R10 commands and count/base changes during busy are ignored
        ie_sw = 1'b0;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'd1);
        set_base(16'h0100);
        push_run(1, 16'h0100, 1'b1);
        wr(3'd0, 8'h03);
        rd(3'd1, v);
        chk(v[0] == 1'b1, "R8 busy during run", 64'(v), 64'h01);
        wr(3'd2, 8'd5);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h07);
        wr(3'd0, 8'h04);
        wait_done("R10 busy run");
        chk(exp_words.size() == 0, "R10 only sampled run streamed", 64'(exp_words.size()), 0);
        repeat (60) @(negedge clk);
        chk(exp_wb.size() == 0 && mem_req == 1'b0, "R10 dropped command stays dropped",
            64'(mem_req), 0);

        // R8 done and enable combinations
        wback(16'h0200, "R8 wb");
        ie_sw = 1'b0;
        wr(3'd2, 8'd0);
        set_base(16'h0000);
        push_run(0, 16'h0000, 1'b0);
        wr(3'd0, 8'h01);
        repeat (40) @(negedge clk);
        chk(irq == 1'b0, "R8 irq low with enable clear", 64'(irq), 0);
        wr(3'd1, 8'h08);
        #1 chk(irq == 1'b1, "R8 irq with enable and done", 64'(irq), 1);
        wr(3'd1, 8'h0C);
        #1 chk(irq == 1'b0, "R8 irq cleared by W1C", 64'(irq), 0);
        rd(3'd1, v);
        chk(v == 8'h08, "R8 status enable kept", 64'(v), 64'h08);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule